// File: doc/BRIEF.md
# Mask-Indexed Pin Configuration Bank

This block is the register side of one 32-line I/O bank. A simple memory-mapped bus with a 6-bit byte address, a write strobe and a write data word reaches it. Read data comes back one cycle after the address is presented. Each line carries a private configuration word, and that word drives the line's pad controls: function select, direction, pull-up, pull-down, input filter, slow filter, open-drain, Schmitt control, drive strength and event select. All of these go to a pad wrapper as flat per-line vectors.

There is no address per line. Software first loads a line-select register with one or more bits set. A single configuration address then writes every selected line at once. A read from that address returns the word of the lowest-numbered selected line.

Output levels live in a latch that software changes only through a write-ones-to-raise port and a write-ones-to-lower port. The latch can be read back. Pin input levels pass through a two-flop synchronizer before software can read them.

Top module: `pin_cfg_bank`

## Requirements
- R1: After reset, the line-select register, every configuration word, the output latch and every pad control output are all 0.
- R2: A write to address 0x00 loads the line-select register, one bit per line with bit n selecting line n. A read of 0x00 returns its value.
- R3: A write to address 0x04 loads the configuration word of every line whose select bit is set. Lines whose select bit is clear keep their configuration. An empty selection changes nothing.
- R4: The configuration word has this layout: function in bits 2:0 (0 is plain GPIO, 1 to 7 are peripheral functions), direction in bit 8 (1 = output), pull-up in bit 9, pull-down in bit 10, filter enable in bit 12, slow filter in bit 13, open-drain in bit 14, Schmitt control in bit 15, drive strength in bits 17:16 and event select in bits 26:24. All other bits are not stored and read as 0.
- R5: A read of 0x04 returns the word of the lowest-numbered selected line. With an empty selection it returns 0.
- R6: Each line's pad control outputs equal the matching fields of that line's configuration word. Function and event select are 3 bits per line and drive strength is 2 bits per line, with line n in slice n of each vector.
- R7: Writing to 0x10 sets every output latch bit whose data bit is 1, and writing to 0x14 clears every output latch bit whose data bit is 1. Zero data bits leave the latch unchanged. The latch drives pad_out, and a read of 0x18 returns it.
- R8: A read of 0x08 returns the pin levels through a two-flop synchronizer. A pin change made before clock edge k shows in the read data registered at edge k+2.
- R9: Address 0x0C and every address that is not mapped read as 0. Writes to 0x08, 0x0C, 0x18 or to unmapped addresses change no state.
- R10: The read data is registered. It reflects the address presented in the cycle before the clock edge that loads it, and a read never changes state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | LINES | Raw pin input levels |
| pad_out | output | LINES | Output latch |
| pad_dir | output | LINES | Direction, 1 = drive |
| pad_pu | output | LINES | Pull-up enable |
| pad_pd | output | LINES | Pull-down enable |
| pad_filt | output | LINES | Input filter enable |
| pad_filt_slow | output | LINES | Slow filter select |
| pad_od | output | LINES | Open-drain enable |
| pad_schmitt | output | LINES | Schmitt control |
| pad_drive | output | 2*LINES | Drive strength per line |
| pad_func | output | 3*LINES | Function select per line |
| pad_evsel | output | 3*LINES | Event select per line |

## Verification
The assertions check on every cycle that a configuration write reaches exactly the selected lines and leaves the others alone. They also check that set and clear writes move only the bits they name, that the output latch holds without such a write, that an empty selection and the lock address read 0, and that writes to read-only addresses disturb nothing. Some properties need long stimulus histories to show, and only the bench's scenarios cover them. These are the per-line round trip of every field over all 32 lines, the lowest-line rule for multi-hot reads, the exact two-edge synchronizer delay, and the dropping of unstored bits.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  localparam int DW = 32;
  localparam int AW = 6;

  localparam logic [AW-1:0] A_SEL  = 6'h00;
  localparam logic [AW-1:0] A_CFG  = 6'h04;
  localparam logic [AW-1:0] A_PDAT = 6'h08;
  localparam logic [AW-1:0] A_LOCK = 6'h0C;
  localparam logic [AW-1:0] A_SET  = 6'h10;
  localparam logic [AW-1:0] A_CLR  = 6'h14;
  localparam logic [AW-1:0] A_OUT  = 6'h18;

  // Bit positions of the configuration word
  localparam int B_FUNC  = 0;
  localparam int B_DIR   = 8;
  localparam int B_PU    = 9;
  localparam int B_PD    = 10;
  localparam int B_FILT  = 12;
  localparam int B_SLOW  = 13;
  localparam int B_OD    = 14;
  localparam int B_SCHM  = 15;
  localparam int B_DRIVE = 16;
  localparam int B_EVSEL = 24;

  typedef struct packed {
    logic [2:0] evsel;
    logic [1:0] drive;
    logic       schmitt;
    logic       od;
    logic       slow;
    logic       filt;
    logic       pd;
    logic       pu;
    logic       dir;
    logic [2:0] func;
  } line_cfg_t;

  function automatic line_cfg_t word_to_cfg(input logic [DW-1:0] w);
    line_cfg_t c;
    c.func    = w[B_FUNC +: 3];
    c.dir     = w[B_DIR];
    c.pu      = w[B_PU];
    c.pd      = w[B_PD];
    c.filt    = w[B_FILT];
    c.slow    = w[B_SLOW];
    c.od      = w[B_OD];
    c.schmitt = w[B_SCHM];
    c.drive   = w[B_DRIVE +: 2];
    c.evsel   = w[B_EVSEL +: 3];
    return c;
  endfunction

  function automatic logic [DW-1:0] cfg_to_word(input line_cfg_t c);
    logic [DW-1:0] w;
    w = '0;
    w[B_FUNC +: 3]  = c.func;
    w[B_DIR]        = c.dir;
    w[B_PU]         = c.pu;
    w[B_PD]         = c.pd;
    w[B_FILT]       = c.filt;
    w[B_SLOW]       = c.slow;
    w[B_OD]         = c.od;
    w[B_SCHM]       = c.schmitt;
    w[B_DRIVE +: 2] = c.drive;
    w[B_EVSEL +: 3] = c.evsel;
    return w;
  endfunction

endpackage

// File: rtl/pcb_sync.sv
module pcb_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) st[k] <= '0;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/pcb_cfg_store.sv
module pcb_cfg_store
  import pcb_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [LINES-1:0]   sel,
  input  line_cfg_t          wcfg,
  output logic [DW-1:0]      rd_word,
  output logic [LINES-1:0]   o_dir,
  output logic [LINES-1:0]   o_pu,
  output logic [LINES-1:0]   o_pd,
  output logic [LINES-1:0]   o_filt,
  output logic [LINES-1:0]   o_slow,
  output logic [LINES-1:0]   o_od,
  output logic [LINES-1:0]   o_schmitt,
  output logic [2*LINES-1:0] o_drive,
  output logic [3*LINES-1:0] o_func,
  output logic [3*LINES-1:0] o_evsel
);

  line_cfg_t [LINES-1:0] cfg_q;
  line_cfg_t             rd_cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      for (int n = 0; n < LINES; n++)
        if (sel[n]) cfg_q[n] <= wcfg;
    end
  end

  // Lowest selected line wins: scan downward, last hit is the lowest
  always_comb begin
    rd_cfg = '0;
    for (int n = LINES - 1; n >= 0; n--)
      if (sel[n]) rd_cfg = cfg_q[n];
  end

  assign rd_word = cfg_to_word(rd_cfg);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign o_dir[g]         = cfg_q[g].dir;
    assign o_pu[g]          = cfg_q[g].pu;
    assign o_pd[g]          = cfg_q[g].pd;
    assign o_filt[g]        = cfg_q[g].filt;
    assign o_slow[g]        = cfg_q[g].slow;
    assign o_od[g]          = cfg_q[g].od;
    assign o_schmitt[g]     = cfg_q[g].schmitt;
    assign o_drive[2*g +: 2] = cfg_q[g].drive;
    assign o_func[3*g +: 3]  = cfg_q[g].func;
    assign o_evsel[3*g +: 3] = cfg_q[g].evsel;
  end

endmodule

// File: rtl/pcb_out_latch.sv
module pcb_out_latch #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [LINES-1:0] bits,
  output logic [LINES-1:0] q
);

  logic [LINES-1:0] set_m;
  logic [LINES-1:0] clr_m;

  assign set_m = set_en ? bits : '0;
  assign clr_m = clr_en ? bits : '0;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q | set_m) & ~clr_m;
  end

endmodule

// File: rtl/pin_cfg_bank.sv
module pin_cfg_bank
  import pcb_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_wr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [LINES-1:0]   pin_in,
  output logic [LINES-1:0]   pad_out,
  output logic [LINES-1:0]   pad_dir,
  output logic [LINES-1:0]   pad_pu,
  output logic [LINES-1:0]   pad_pd,
  output logic [LINES-1:0]   pad_filt,
  output logic [LINES-1:0]   pad_filt_slow,
  output logic [LINES-1:0]   pad_od,
  output logic [LINES-1:0]   pad_schmitt,
  output logic [2*LINES-1:0] pad_drive,
  output logic [3*LINES-1:0] pad_func,
  output logic [3*LINES-1:0] pad_evsel
);

  localparam int SYNC_STAGES = 2;

  logic [LINES-1:0] mask_q;
  logic [LINES-1:0] pin_s;
  logic [DW-1:0]    cfg_rd;
  logic [DW-1:0]    pin_ext;
  logic [DW-1:0]    out_ext;
  logic [DW-1:0]    sel_ext;
  logic [DW-1:0]    rdata_q;

  logic wr_sel, wr_cfg, wr_set, wr_clr;

  assign wr_sel = bus_wr && (bus_addr == A_SEL);
  assign wr_cfg = bus_wr && (bus_addr == A_CFG);
  assign wr_set = bus_wr && (bus_addr == A_SET);
  assign wr_clr = bus_wr && (bus_addr == A_CLR);

  always_ff @(posedge clk) begin
    if (rst)         mask_q <= '0;
    else if (wr_sel) mask_q <= bus_wdata[LINES-1:0];
  end

  pcb_cfg_store #(.LINES(LINES)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_cfg),
    .sel       (mask_q),
    .wcfg      (word_to_cfg(bus_wdata)),
    .rd_word   (cfg_rd),
    .o_dir     (pad_dir),
    .o_pu      (pad_pu),
    .o_pd      (pad_pd),
    .o_filt    (pad_filt),
    .o_slow    (pad_filt_slow),
    .o_od      (pad_od),
    .o_schmitt (pad_schmitt),
    .o_drive   (pad_drive),
    .o_func    (pad_func),
    .o_evsel   (pad_evsel)
  );

  pcb_out_latch #(.LINES(LINES)) u_out (
    .clk    (clk),
    .rst    (rst),
    .set_en (wr_set),
    .clr_en (wr_clr),
    .bits   (bus_wdata[LINES-1:0]),
    .q      (pad_out)
  );

  pcb_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_s)
  );

  always_comb begin
    pin_ext = '0;
    pin_ext[LINES-1:0] = pin_s;
    out_ext = '0;
    out_ext[LINES-1:0] = pad_out;
    sel_ext = '0;
    sel_ext[LINES-1:0] = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (bus_addr)
        A_SEL:   rdata_q <= sel_ext;
        A_CFG:   rdata_q <= cfg_rd;
        A_PDAT:  rdata_q <= pin_ext;
        A_OUT:   rdata_q <= out_ext;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker
  import pcb_pkg::*;
#(
  parameter int LINES = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [AW-1:0]      bus_addr,
  input logic               bus_wr,
  input logic [DW-1:0]      bus_wdata,
  input logic [DW-1:0]      bus_rdata,
  input logic [LINES-1:0]   mask_q,
  input logic [LINES-1:0]   pad_out,
  input logic [LINES-1:0]   pad_dir,
  input logic [2*LINES-1:0] pad_drive,
  input logic [3*LINES-1:0] pad_func
);

  logic setw, clrw;
  assign setw = bus_wr && (bus_addr == A_SET);
  assign clrw = bus_wr && (bus_addr == A_CLR);

  for (genvar g = 0; g < LINES; g++) begin : g_ln
    // R3: unselected line untouched by a configuration write
    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == A_CFG && !mask_q[g]) |=>
        ($stable(pad_func[3*g +: 3]) && $stable(pad_drive[2*g +: 2]) && $stable(pad_dir[g])));
    // R3 / R6: selected line takes the written fields
    assert_cfg_load_R3: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == A_CFG && mask_q[g]) |=>
        (pad_func[3*g +: 3] == $past(bus_wdata[B_FUNC +: 3]) &&
         pad_dir[g] == $past(bus_wdata[B_DIR]) &&
         pad_drive[2*g +: 2] == $past(bus_wdata[B_DRIVE +: 2])));
  end

  assert_set_bits_R7: assert property (@(posedge clk) disable iff (rst)
    setw |=> ((pad_out & $past(bus_wdata[LINES-1:0])) == $past(bus_wdata[LINES-1:0])));

  assert_clr_bits_R7: assert property (@(posedge clk) disable iff (rst)
    clrw |=> ((pad_out & $past(bus_wdata[LINES-1:0])) == '0));

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!setw && !clrw) |=> $stable(pad_out));

  assert_empty_read_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_CFG && mask_q == '0) |=> (bus_rdata == '0));

  assert_lock_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == A_LOCK) |=> (bus_rdata == '0));

  assert_ro_write_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == A_PDAT || bus_addr == A_OUT || bus_addr == A_LOCK)) |=>
      ($stable(pad_out) && $stable(mask_q) && $stable(pad_func)));

endmodule

bind pin_cfg_bank pcb_checker #(.LINES(LINES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .mask_q    (mask_q),
  .pad_out   (pad_out),
  .pad_dir   (pad_dir),
  .pad_drive (pad_drive),
  .pad_func  (pad_func)
);

// File: tb/tb_pin_cfg_bank.sv
module tb_pin_cfg_bank;

  localparam int L = 32;
  localparam logic [31:0] IMPL = 32'h0703_F707;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [5:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [L-1:0]  pin_in = '0;
  logic [L-1:0]  pad_out, pad_dir, pad_pu, pad_pd, pad_filt, pad_filt_slow, pad_od, pad_schmitt;
  logic [2*L-1:0] pad_drive;
  logic [3*L-1:0] pad_func, pad_evsel;

  int checks = 0;
  int failures = 0;
  logic [31:0] model [L];
  logic [31:0] out_m = '0;
  logic [31:0] sel_m = '0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  pin_cfg_bank #(.LINES(L)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_out(pad_out), .pad_dir(pad_dir), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pad_filt(pad_filt), .pad_filt_slow(pad_filt_slow), .pad_od(pad_od),
    .pad_schmitt(pad_schmitt), .pad_drive(pad_drive), .pad_func(pad_func),
    .pad_evsel(pad_evsel)
  );

  task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rdb(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [31:0] pat(input int i);
    logic [31:0] w;
    logic [4:0] b;
    b = 5'(i);
    w = 32'hF8FC_08F8;
    w[2:0]   = 3'(i % 8);
    w[8]     = b[0];
    w[9]     = b[1];
    w[10]    = b[2];
    w[12]    = b[3];
    w[13]    = b[4];
    w[14]    = ~b[0];
    w[15]    = b[1] ^ b[2];
    w[17:16] = 2'(i % 4);
    w[26:24] = 3'((i * 3) % 8);
    return w;
  endfunction

  function automatic logic [31:0] lowest_word(input logic [31:0] s);
    for (int n = 0; n < L; n++) if (s[n]) return model[n];
    return 32'h0;
  endfunction

  // R6: every pad control equals the model's fields
  task automatic check_pads(input string req);
    logic [3*L-1:0] ef, ee;
    logic [2*L-1:0] ed;
    logic [L-1:0] edir, epu, epd, efl, esl, eod, esc;
    for (int j = 0; j < L; j++) begin
      ef[3*j +: 3] = model[j][2:0];
      ee[3*j +: 3] = model[j][26:24];
      ed[2*j +: 2] = model[j][17:16];
      edir[j] = model[j][8];  epu[j] = model[j][9];  epd[j] = model[j][10];
      efl[j]  = model[j][12]; esl[j] = model[j][13]; eod[j] = model[j][14];
      esc[j]  = model[j][15];
    end
    chk(pad_func == ef,  {req, " R6 func"},  pad_func, ef);
    chk(pad_evsel == ee, {req, " R6 evsel"}, pad_evsel, ee);
    chk(pad_drive == ed, {req, " R6 drive"}, pad_drive, ed);
    chk({pad_dir, pad_pu, pad_pd, pad_filt} == {edir, epu, epd, efl}, {req, " R6 dir/pull/filt"},
        {pad_dir, pad_pu, pad_pd, pad_filt}, {edir, epu, epd, efl});
    chk({pad_filt_slow, pad_od, pad_schmitt} == {esl, eod, esc}, {req, " R6 slow/od/schmitt"},
        {pad_filt_slow, pad_od, pad_schmitt}, {esl, eod, esc});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int n = 0; n < L; n++) model[n] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    @(negedge clk);
    chk(pad_out == '0, "R1 pad_out", pad_out, 0);
    check_pads("R1");
    rdb(6'h00, rd); chk(rd == 0, "R1 select", rd, 0);
    rdb(6'h04, rd); chk(rd == 0, "R1/R5 empty cfg read", rd, 0);

    // R2: select register round trip
    wr(6'h00, 32'h8001_2340); sel_m = 32'h8001_2340;
    rdb(6'h00, rd); chk(rd == sel_m, "R2 select readback", rd, sel_m);

    // R3/R4: per-line sweep with one-hot selection
    for (int i = 0; i < L; i++) begin
      wr(6'h00, 32'h1 << i); sel_m = 32'h1 << i;
      wr(6'h04, pat(i)); model[i] = pat(i) & IMPL;
      rdb(6'h04, rd);
      chk(rd == model[i], "R4 cfg readback, unstored bits zero", rd, model[i]);
    end
    check_pads("R3 sweep");

    // R3/R5: multi-hot write, lowest line read
    wr(6'h00, 32'hA5A5_0F00); sel_m = 32'hA5A5_0F00;
    wr(6'h04, 32'hFFFF_FFFF);
    for (int n = 0; n < L; n++) if (sel_m[n]) model[n] = IMPL;
    check_pads("R3 multi-hot");
    wr(6'h04 - 6'h00, 32'h0) ; // overwrite selected with zero via same addr
    for (int n = 0; n < L; n++) if (sel_m[n]) model[n] = '0;
    wr(6'h00, 32'h0000_0003); sel_m = 32'h3;
    rdb(6'h04, rd); chk(rd == lowest_word(sel_m), "R5 lowest of lines 0,1", rd, lowest_word(sel_m));
    wr(6'h00, 32'hC000_0000); sel_m = 32'hC000_0000;
    rdb(6'h04, rd); chk(rd == lowest_word(sel_m), "R5 lowest of lines 30,31", rd, lowest_word(sel_m));

    // R3: empty selection changes nothing
    wr(6'h00, 32'h0); sel_m = 0;
    wr(6'h04, 32'h0703_F707);
    check_pads("R3 empty select");
    rdb(6'h04, rd); chk(rd == 0, "R5 empty select read", rd, 0);

    // R7: set / clear patterns
    for (int k = 0; k < 6; k++) begin
      logic [31:0] sv, cv;
      sv = 32'h9E37_79B9 * (k + 1);
      cv = 32'h7F4A_7C15 * (k + 3);
      wr(6'h10, sv); out_m = out_m | sv;
      chk(pad_out == out_m, "R7 set", pad_out, out_m);
      wr(6'h14, cv); out_m = out_m & ~cv;
      chk(pad_out == out_m, "R7 clear", pad_out, out_m);
      rdb(6'h18, rd); chk(rd == out_m, "R7 latch readback", rd, out_m);
    end
    wr(6'h10, 32'h0); chk(pad_out == out_m, "R7 zero set no effect", pad_out, out_m);
    wr(6'h14, 32'h0); chk(pad_out == out_m, "R7 zero clear no effect", pad_out, out_m);

    // R8: exact synchronizer delay
    @(negedge clk);
    bus_addr = 6'h08; pin_in = 32'h5A5A_F00F;
    @(negedge clk); chk(bus_rdata == 0, "R8 not yet after 1 edge", bus_rdata, 0);
    @(negedge clk); chk(bus_rdata == 0, "R8 not yet after 2 edges", bus_rdata, 0);
    @(negedge clk); chk(bus_rdata == 32'h5A5A_F00F, "R8 visible after 3rd edge", bus_rdata, 32'h5A5A_F00F);
    for (int i = 0; i < L; i++) begin
      @(negedge clk); pin_in = 32'h1 << i;
      repeat (3) @(negedge clk);
      chk(bus_rdata == (32'h1 << i), "R8 walking one", bus_rdata, 32'h1 << i);
    end

    // R9: lock and unmapped addresses, ignored writes
    rdb(6'h0C, rd); chk(rd == 0, "R9 lock reads 0", rd, 0);
    rdb(6'h1C, rd); chk(rd == 0, "R9 unmapped 0x1C", rd, 0);
    rdb(6'h3C, rd); chk(rd == 0, "R9 unmapped 0x3C", rd, 0);
    wr(6'h00, 32'h0000_0010); sel_m = 32'h10;
    wr(6'h08, 32'hFFFF_FFFF); wr(6'h0C, 32'hFFFF_FFFF);
    wr(6'h18, 32'h1234_5678); wr(6'h3C, 32'hFFFF_FFFF); wr(6'h05, 32'hFFFF_FFFF);
    chk(pad_out == out_m, "R9 ignored writes keep latch", pad_out, out_m);
    check_pads("R9 ignored writes");
    rdb(6'h00, rd); chk(rd == sel_m, "R9 ignored writes keep select", rd, sel_m);

    // R10: read data follows the previous cycle's address
    @(negedge clk); bus_addr = 6'h18;
    @(negedge clk); chk(bus_rdata == out_m, "R10 read out", bus_rdata, out_m);
    bus_addr = 6'h00;
    @(negedge clk); chk(bus_rdata == sel_m, "R10 next address", bus_rdata, sel_m);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule